// File: doc/BRIEF.md
# BCH Error-Correction Register Front-End

This block is the register shell and stream sequencer that sits in front of a NAND-style BCH error-correction engine. Software programs it over a simple 32-bit register bus: a four-bit control word that changes only through set and clear aliases, a pair of byte-count limits (one for encoding, one for decoding), a write-one-to-clear status word and an interrupt mask. Payload bytes are pushed one per write into a data port. The block forwards each accepted byte to the engine, counts it, watches whether the block so far is all 0x00 or all 0xFF, and raises the matching done flag when the programmed count is reached.

The arithmetic engine is outside this block. It returns parity bytes, error bit positions and an error summary through a valid-qualified side interface. This block packs those into readable words and freezes them once the operation completes, until the next initialisation. The engine is expected to deliver every result before the final byte of the operation is accepted.

Top module: `ecc_ctrl_regs`

## Requirements
- R1: After reset every readable register (offsets 0x00 to 0x40) reads zero and `irq` is low.
- R2: Control bits are bit0 enable, bit1 init, bit2 strength-8 select, bit3 encode select. Control is read at 0x00. A write to 0x04 ORs the written low four bits into control, a write to 0x08 clears them, and a write to 0x00 has no effect.
- R3: While the init bit is 1 for a cycle, the byte counter, block trackers, done state, status word and parity/error stores are cleared at the end of that cycle. The init bit then reads 0 without any further write.
- R4: The count register at 0x0C holds the encode count in bits 9:0 and the decode count in bits 25:16. All other bits read 0.
- R5: With encode selected, status bit2 reads 1 in the cycle after the write that brings the accepted-byte count to the encode count. A count of zero never completes.
- R6: With decode selected, status bit3 is set when the decode count is reached. At that point bit0 is set if any error position was collected, bit1 copies the engine's uncorrectable flag, bits 22:16 take the engine's total error count and bits 31:28 take the number of collected error positions.
- R7: On completion, status bit4 is set if every accepted byte of the block was 0xFF, and bit5 is set if every byte was 0x00.
- R8: Data-port writes at 0x10 are ignored and not forwarded while enable is clear, and after the current operation has completed until the next init.
- R9: Writing to the status word at 0x24 clears exactly the bits written as 1 and leaves the others.
- R10: Parity bytes from the engine are packed little-endian: byte k lands in word 0x14+4*(k/4), bits 8*(k%4)+7:8*(k%4). Bytes beyond the store's capacity (16 by default) are dropped.
- R11: Error positions are stored two per word from 0x28. Position i goes to word 0x28+4*(i/2), in bits 12:0 when i is even and in bits 28:16 when i is odd. Positions beyond capacity (8 by default) are dropped.
- R12: After completion, engine parity, error and summary inputs are ignored until the next init.
- R13: The interrupt mask reads at 0x38. A write to 0x3C sets mask bits and a write to 0x40 clears them. `irq` is high exactly when some status bit among 5:0 is 1 and its mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| eng_enable | output | 1 | Control enable bit |
| eng_init | output | 1 | One-cycle initialisation pulse |
| eng_t8 | output | 1 | Strength-8 select |
| eng_encode | output | 1 | Encode select |
| eng_byte_vld | output | 1 | An accepted payload byte is on `eng_byte` |
| eng_byte | output | 8 | Payload byte |
| eng_par_vld | input | 1 | Parity byte valid |
| eng_par_byte | input | 8 | Parity byte |
| eng_err_vld | input | 1 | Error position valid |
| eng_err_pos | input | 13 | Bit position of an error |
| eng_res_vld | input | 1 | Error summary valid |
| eng_err_total | input | 7 | Total error count |
| eng_uncor | input | 1 | Block uncorrectable |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong byte count or tracker shows up as a done flag, or an all-0x00/all-0xFF flag, that appears one write too early or too late, or not at all. The check comes in the cycle after the final byte, on both the status read and `irq`. A store that keeps accepting after completion, or packs to the wrong lane, changes a parity or error word that the next register dump exposes. A control bit that stays set or fails to self-clear is seen on `eng_init` in the next cycle, because the bench compares the model against the ports on every clock.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;
  // Register byte offsets (software decodes these)
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_CSET  = 8'h04;
  localparam logic [7:0] OFS_CCLR  = 8'h08;
  localparam logic [7:0] OFS_COUNT = 8'h0C;
  localparam logic [7:0] OFS_DATA  = 8'h10;
  localparam logic [7:0] OFS_PAR   = 8'h14;
  localparam logic [7:0] OFS_STAT  = 8'h24;
  localparam logic [7:0] OFS_ERRIX = 8'h28;
  localparam logic [7:0] OFS_IEN   = 8'h38;
  localparam logic [7:0] OFS_IESET = 8'h3C;
  localparam logic [7:0] OFS_IECLR = 8'h40;

  localparam int CTRL_W = 4;
  localparam int CB_EN   = 0;
  localparam int CB_INIT = 1;
  localparam int CB_T8   = 2;
  localparam int CB_ENC  = 3;

  localparam int FLAG_W  = 6;
  localparam int SB_ERR  = 0;
  localparam int SB_UNC  = 1;
  localparam int SB_ENCD = 2;
  localparam int SB_DECD = 3;
  localparam int SB_ONES = 4;
  localparam int SB_ZERO = 5;
  localparam int TOT_LSB  = 16;
  localparam int TOT_W    = 7;
  localparam int ERRC_LSB = 28;
  localparam int ERRC_W   = 4;

  localparam int CNT_W  = 10;
  localparam int ENC_LSB = 0;
  localparam int DEC_LSB = 16;
  localparam int POS_W  = 13;
endpackage

// File: rtl/ecc_byte_tracker.sv
module ecc_byte_tracker #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             data_wr,
  input  logic             enable,
  input  logic [7:0]       data_byte,
  input  logic [CNT_W-1:0] target,
  output logic             accept,
  output logic             done_evt,
  output logic             blk_zero,
  output logic             blk_ones,
  output logic             op_done
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             zero_q, zero_d, ones_q, ones_d, done_q, done_d;
  logic             trk_en;

  assign accept   = data_wr & enable & ~done_q & ~clr;
  assign cnt_inc  = cnt_q + 1'b1;
  assign done_evt = accept && (target != '0) && (cnt_inc == target);
  assign blk_zero = zero_q && (data_byte == 8'h00);
  assign blk_ones = ones_q && (data_byte == 8'hFF);
  assign op_done  = done_q;
  assign trk_en   = clr | accept;

  always_comb begin
    cnt_d  = cnt_q;
    zero_d = zero_q;
    ones_d = ones_q;
    done_d = done_q;
    if (clr) begin
      cnt_d  = '0;
      zero_d = 1'b1;
      ones_d = 1'b1;
      done_d = 1'b0;
    end else if (accept) begin
      cnt_d  = cnt_inc;
      zero_d = blk_zero;
      ones_d = blk_ones;
      done_d = done_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      zero_q <= 1'b1;
      ones_q <= 1'b1;
      done_q <= 1'b0;
    end else if (trk_en) begin
      cnt_q  <= cnt_d;
      zero_q <= zero_d;
      ones_q <= ones_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/ecc_result_store.sv
module ecc_result_store #(
  parameter int PAR_WORDS = 4,
  parameter int ERR_WORDS = 4,
  parameter int POS_W     = 13,
  parameter int TOT_W     = 7,
  localparam int PAR_BYTES = 4 * PAR_WORDS,
  localparam int ERR_SLOTS = 2 * ERR_WORDS,
  localparam int PAR_CW    = $clog2(PAR_BYTES + 1),
  localparam int ERR_CW    = $clog2(ERR_SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    freeze,
  input  logic                    par_vld,
  input  logic [7:0]              par_byte,
  input  logic                    err_vld,
  input  logic [POS_W-1:0]        err_pos,
  input  logic                    res_vld,
  input  logic [TOT_W-1:0]        res_total,
  input  logic                    res_uncor,
  output logic [PAR_WORDS*32-1:0] par_flat,
  output logic [ERR_WORDS*32-1:0] err_flat,
  output logic [ERR_CW-1:0]       err_n,
  output logic [TOT_W-1:0]        total_q,
  output logic                    uncor_q
);
  logic [PAR_CW-1:0] par_n_q, par_n_d;
  logic [ERR_CW-1:0] err_n_q, err_n_d;
  logic              par_take, err_take, res_take;

  assign par_take = par_vld && !freeze && !clr && (par_n_q < PAR_CW'(PAR_BYTES));
  assign err_take = err_vld && !freeze && !clr && (err_n_q < ERR_CW'(ERR_SLOTS));
  assign res_take = res_vld && !freeze && !clr;
  assign err_n    = err_n_q;

  always_comb begin
    par_n_d = par_n_q;
    err_n_d = err_n_q;
    if (clr) begin
      par_n_d = '0;
      err_n_d = '0;
    end else begin
      if (par_take) par_n_d = par_n_q + 1'b1;
      if (err_take) err_n_d = err_n_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      par_n_q <= '0;
      err_n_q <= '0;
    end else if (clr | par_take | err_take) begin
      par_n_q <= par_n_d;
      err_n_q <= err_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total_q <= '0;
      uncor_q <= 1'b0;
    end else if (clr) begin
      total_q <= '0;
      uncor_q <= 1'b0;
    end else if (res_take) begin
      total_q <= res_total;
      uncor_q <= res_uncor;
    end
  end

  // Parity lanes: byte g sits at bit 8*g of the flat vector (little-endian words)
  for (genvar g = 0; g < PAR_BYTES; g++) begin : g_par
    logic [7:0] b_q;
    logic       b_we;
    assign b_we = par_take && (par_n_q == PAR_CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_q <= '0;
      else if (clr)  b_q <= '0;
      else if (b_we) b_q <= par_byte;
    end
    assign par_flat[g*8 +: 8] = b_q;
  end

  // Error slots: even slot in the low half-word, odd slot in the high half-word
  for (genvar g = 0; g < ERR_SLOTS; g++) begin : g_err
    logic [POS_W-1:0] e_q;
    logic             e_we;
    assign e_we = err_take && (err_n_q == ERR_CW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    e_q <= '0;
      else if (clr)  e_q <= '0;
      else if (e_we) e_q <= err_pos;
    end
    assign err_flat[(g/2)*32 + (g%2)*16 +: POS_W]              = e_q;
    assign err_flat[(g/2)*32 + (g%2)*16 + POS_W +: 16 - POS_W] = '0;
  end
endmodule

// File: rtl/ecc_ctrl_regs.sv
module ecc_ctrl_regs
  import ecc_regs_pkg::*;
#(
  parameter int PAR_WORDS = 4,
  parameter int ERR_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              eng_enable,
  output logic              eng_init,
  output logic              eng_t8,
  output logic              eng_encode,
  output logic              eng_byte_vld,
  output logic [7:0]        eng_byte,
  input  logic              eng_par_vld,
  input  logic [7:0]        eng_par_byte,
  input  logic              eng_err_vld,
  input  logic [POS_W-1:0]  eng_err_pos,
  input  logic              eng_res_vld,
  input  logic [TOT_W-1:0]  eng_err_total,
  input  logic              eng_uncor,
  output logic              irq
);
  localparam int ERR_SLOTS = 2 * ERR_WORDS;
  localparam int ERR_CW    = $clog2(ERR_SLOTS + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // Write decode
  logic wr_cset, wr_cclr, wr_count, wr_data, wr_stat, wr_ieset, wr_ieclr;
  assign wr_cset  = bus_wr && (bus_addr == OFS_CSET);
  assign wr_cclr  = bus_wr && (bus_addr == OFS_CCLR);
  assign wr_count = bus_wr && (bus_addr == OFS_COUNT);
  assign wr_data  = bus_wr && (bus_addr == OFS_DATA);
  assign wr_stat  = bus_wr && (bus_addr == OFS_STAT);
  assign wr_ieset = bus_wr && (bus_addr == OFS_IESET);
  assign wr_ieclr = bus_wr && (bus_addr == OFS_IECLR);

  // Control word
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              ctrl_en, core_clr;
  assign core_clr = ctrl_q[CB_INIT];
  assign ctrl_en  = core_clr | wr_cset | wr_cclr;

  always_comb begin
    ctrl_d          = ctrl_q;
    ctrl_d[CB_INIT] = 1'b0;
    if (wr_cset) ctrl_d = ctrl_d | bus_wdata[CTRL_W-1:0];
    if (wr_cclr) ctrl_d = ctrl_d & ~bus_wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // Count limits
  logic [CNT_W-1:0] enc_lim_q, dec_lim_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      enc_lim_q <= '0;
      dec_lim_q <= '0;
    end else if (wr_count) begin
      enc_lim_q <= bus_wdata[ENC_LSB +: CNT_W];
      dec_lim_q <= bus_wdata[DEC_LSB +: CNT_W];
    end
  end

  // Interrupt mask
  logic [FLAG_W-1:0] ien_q, ien_d;
  always_comb begin
    ien_d = ien_q;
    if (wr_ieset) ien_d = ien_d | bus_wdata[FLAG_W-1:0];
    if (wr_ieclr) ien_d = ien_d & ~bus_wdata[FLAG_W-1:0];
  end
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)             ien_q <= '0;
    else if (wr_ieset | wr_ieclr) ien_q <= ien_d;
  end

  // Byte stream sequencing
  logic             accept, done_evt, blk_zero, blk_ones, trk_done;
  logic [CNT_W-1:0] target;
  assign target = ctrl_q[CB_ENC] ? enc_lim_q : dec_lim_q;

  ecc_byte_tracker #(.CNT_W(CNT_W)) u_trk (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr       (core_clr),
    .data_wr   (wr_data),
    .enable    (ctrl_q[CB_EN]),
    .data_byte (bus_wdata[7:0]),
    .target    (target),
    .accept    (accept),
    .done_evt  (done_evt),
    .blk_zero  (blk_zero),
    .blk_ones  (blk_ones),
    .op_done   (trk_done)
  );

  // Engine results
  logic [PAR_WORDS*32-1:0] par_flat;
  logic [ERR_WORDS*32-1:0] err_flat;
  logic [ERR_CW-1:0]       err_n;
  logic [TOT_W-1:0]        res_tot;
  logic                    res_unc;

  ecc_result_store #(
    .PAR_WORDS (PAR_WORDS),
    .ERR_WORDS (ERR_WORDS),
    .POS_W     (POS_W),
    .TOT_W     (TOT_W)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .clr       (core_clr),
    .freeze    (trk_done),
    .par_vld   (eng_par_vld),
    .par_byte  (eng_par_byte),
    .err_vld   (eng_err_vld),
    .err_pos   (eng_err_pos),
    .res_vld   (eng_res_vld),
    .res_total (eng_err_total),
    .res_uncor (eng_uncor),
    .par_flat  (par_flat),
    .err_flat  (err_flat),
    .err_n     (err_n),
    .total_q   (res_tot),
    .uncor_q   (res_unc)
  );

  // Status word
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic [TOT_W-1:0]  tot_q, tot_d;
  logic [ERRC_W-1:0] errc_q, errc_d;
  logic              stat_en;
  logic [31:0]       status_w;

  assign stat_en = core_clr | done_evt | wr_stat;

  always_comb begin
    flags_d = flags_q;
    tot_d   = tot_q;
    errc_d  = errc_q;
    if (core_clr) begin
      flags_d = '0;
      tot_d   = '0;
      errc_d  = '0;
    end else if (done_evt) begin
      if (ctrl_q[CB_ENC]) begin
        flags_d[SB_ENCD] = 1'b1;
      end else begin
        flags_d[SB_DECD] = 1'b1;
        flags_d[SB_ERR]  = flags_q[SB_ERR] | (err_n != '0);
        flags_d[SB_UNC]  = flags_q[SB_UNC] | res_unc;
        tot_d            = res_tot;
        errc_d           = ERRC_W'(err_n);
      end
      if (blk_ones) flags_d[SB_ONES] = 1'b1;
      if (blk_zero) flags_d[SB_ZERO] = 1'b1;
    end else if (wr_stat) begin
      flags_d = flags_q & ~bus_wdata[FLAG_W-1:0];
      tot_d   = tot_q   & ~bus_wdata[TOT_LSB +: TOT_W];
      errc_d  = errc_q  & ~bus_wdata[ERRC_LSB +: ERRC_W];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      flags_q <= '0;
      tot_q   <= '0;
      errc_q  <= '0;
    end else if (stat_en) begin
      flags_q <= flags_d;
      tot_q   <= tot_d;
      errc_q  <= errc_d;
    end
  end

  always_comb begin
    status_w                       = '0;
    status_w[FLAG_W-1:0]           = flags_q;
    status_w[TOT_LSB +: TOT_W]     = tot_q;
    status_w[ERRC_LSB +: ERRC_W]   = errc_q;
  end

  // Read mux
  always_comb begin
    bus_rdata = '0;
    for (int w = 0; w < PAR_WORDS; w++)
      if (bus_addr == OFS_PAR + 8'(4 * w)) bus_rdata = par_flat[w*32 +: 32];
    for (int w = 0; w < ERR_WORDS; w++)
      if (bus_addr == OFS_ERRIX + 8'(4 * w)) bus_rdata = err_flat[w*32 +: 32];
    case (bus_addr)
      OFS_CTRL:  bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
      OFS_COUNT: begin
        bus_rdata                      = '0;
        bus_rdata[ENC_LSB +: CNT_W]    = enc_lim_q;
        bus_rdata[DEC_LSB +: CNT_W]    = dec_lim_q;
      end
      OFS_STAT:  bus_rdata = status_w;
      OFS_IEN:   bus_rdata = {{(32-FLAG_W){1'b0}}, ien_q};
      default: ;
    endcase
  end

  assign eng_enable   = ctrl_q[CB_EN];
  assign eng_init     = ctrl_q[CB_INIT];
  assign eng_t8       = ctrl_q[CB_T8];
  assign eng_encode   = ctrl_q[CB_ENC];
  assign eng_byte_vld = accept;
  assign eng_byte     = bus_wdata[7:0];
  assign irq          = |(flags_q & ien_q);
endmodule

// File: rtl/ecc_ctrl_regs_chk.sv
module ecc_ctrl_regs_chk
  import ecc_regs_pkg::*;
#(
  parameter int PAR_WORDS = 4,
  parameter int ERR_WORDS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bus_wr,
  input logic [7:0]              bus_addr,
  input logic [31:0]             bus_wdata,
  input logic                    eng_init,
  input logic                    eng_enable,
  input logic                    eng_byte_vld,
  input logic                    irq,
  input logic [31:0]             status,
  input logic [FLAG_W-1:0]       inten,
  input logic                    op_done,
  input logic [PAR_WORDS*32-1:0] par_flat,
  input logic [ERR_WORDS*32-1:0] err_flat
);
  // R3
  init_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_init && !(bus_wr && bus_addr == OFS_CSET && bus_wdata[CB_INIT])) |=> !eng_init);

  // R3
  init_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_init |=> (status == 32'h0 && !op_done));

  // R5
  done_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[SB_ENCD]) || $rose(status[SB_DECD])) |-> $past(eng_byte_vld));

  // R8
  byte_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_byte_vld |-> (eng_enable && !op_done));

  // R12
  par_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !eng_init) |=> $stable(par_flat));

  // R12
  err_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && !eng_init) |=> $stable(err_flat));

  // R13
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inten == '0) |-> !irq);
endmodule

bind ecc_ctrl_regs ecc_ctrl_regs_chk #(
  .PAR_WORDS (PAR_WORDS),
  .ERR_WORDS (ERR_WORDS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .bus_wr       (bus_wr),
  .bus_addr     (bus_addr),
  .bus_wdata    (bus_wdata),
  .eng_init     (eng_init),
  .eng_enable   (eng_enable),
  .eng_byte_vld (eng_byte_vld),
  .irq          (irq),
  .status       (status_w),
  .inten        (ien_q),
  .op_done      (trk_done),
  .par_flat     (par_flat),
  .err_flat     (err_flat)
);

// File: tb/ecc_ctrl_regs_bench.sv
`timescale 1ns/1ps
module ecc_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        eng_enable, eng_init, eng_t8, eng_encode, eng_byte_vld;
  logic [7:0]  eng_byte;
  logic        eng_par_vld;
  logic [7:0]  eng_par_byte;
  logic        eng_err_vld;
  logic [12:0] eng_err_pos;
  logic        eng_res_vld;
  logic [6:0]  eng_err_total;
  logic        eng_uncor;
  logic        irq;

  always #5 clk = ~clk;

  ecc_ctrl_regs u_ecc_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_enable(eng_enable),
    .eng_init(eng_init), .eng_t8(eng_t8), .eng_encode(eng_encode),
    .eng_byte_vld(eng_byte_vld), .eng_byte(eng_byte), .eng_par_vld(eng_par_vld),
    .eng_par_byte(eng_par_byte), .eng_err_vld(eng_err_vld), .eng_err_pos(eng_err_pos),
    .eng_res_vld(eng_res_vld), .eng_err_total(eng_err_total), .eng_uncor(eng_uncor),
    .irq(irq)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // Behavioural reference state
  logic [3:0]  m_ctrl;
  int          m_enc, m_dec;
  logic [5:0]  m_ien;
  logic [31:0] m_stat;
  int          m_cnt;
  bit          m_z, m_o, m_done;
  logic [7:0]  m_par_b [16];
  logic [12:0] m_err_e [8];
  int          m_parn, m_errn;
  logic [6:0]  m_tot;
  bit          m_unc;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_clear_op();
    m_cnt = 0; m_z = 1; m_o = 1; m_done = 0;
    m_stat = '0; m_parn = 0; m_errn = 0; m_tot = '0; m_unc = 0;
    foreach (m_par_b[i]) m_par_b[i] = '0;
    foreach (m_err_e[i]) m_err_e[i] = '0;
  endtask

  task automatic model_step();
    bit done_before;
    int tgt;
    logic [7:0] b;
    done_before = m_done;
    if (m_ctrl[1]) begin
      model_clear_op();
    end else begin
      if (bus_wr && bus_addr == 8'h10 && m_ctrl[0] && !m_done) begin
        b = bus_wdata[7:0];
        m_cnt++;
        m_z = m_z && (b == 8'h00);
        m_o = m_o && (b == 8'hFF);
        tgt = m_ctrl[3] ? m_enc : m_dec;
        if (tgt != 0 && m_cnt == tgt) begin
          m_done = 1;
          if (m_ctrl[3]) m_stat[2] = 1'b1;
          else begin
            m_stat[3] = 1'b1;
            if (m_errn != 0) m_stat[0] = 1'b1;
            if (m_unc)       m_stat[1] = 1'b1;
            m_stat[22:16] = m_tot;
            m_stat[31:28] = 4'(m_errn);
          end
          if (m_o) m_stat[4] = 1'b1;
          if (m_z) m_stat[5] = 1'b1;
        end
      end
      if (!done_before) begin
        if (eng_par_vld && m_parn < 16) begin m_par_b[m_parn] = eng_par_byte; m_parn++; end
        if (eng_err_vld && m_errn < 8)  begin m_err_e[m_errn] = eng_err_pos;  m_errn++; end
        if (eng_res_vld) begin m_tot = eng_err_total; m_unc = eng_uncor; end
      end
      if (bus_wr && bus_addr == 8'h24) m_stat = m_stat & ~bus_wdata;
    end
    m_ctrl[1] = 1'b0;
    if (bus_wr && bus_addr == 8'h04) m_ctrl = m_ctrl | bus_wdata[3:0];
    if (bus_wr && bus_addr == 8'h08) m_ctrl = m_ctrl & ~bus_wdata[3:0];
    if (bus_wr && bus_addr == 8'h0C) begin m_enc = int'(bus_wdata[9:0]); m_dec = int'(bus_wdata[25:16]); end
    if (bus_wr && bus_addr == 8'h3C) m_ien = m_ien | bus_wdata[5:0];
    if (bus_wr && bus_addr == 8'h40) m_ien = m_ien & ~bus_wdata[5:0];
  endtask

  function automatic logic [31:0] model_read(logic [7:0] a);
    int i;
    if (a == 8'h00) return {28'h0, m_ctrl};
    if (a == 8'h0C) return {6'h0, 10'(m_dec), 6'h0, 10'(m_enc)};
    if (a == 8'h24) return m_stat;
    if (a == 8'h38) return {26'h0, m_ien};
    if (a >= 8'h14 && a <= 8'h20 && a[1:0] == 2'b00) begin
      i = (int'(a) - 'h14) / 4;
      return {m_par_b[4*i+3], m_par_b[4*i+2], m_par_b[4*i+1], m_par_b[4*i]};
    end
    if (a >= 8'h28 && a <= 8'h34 && a[1:0] == 2'b00) begin
      i = (int'(a) - 'h28) / 4;
      return {3'b000, m_err_e[2*i+1], 3'b000, m_err_e[2*i]};
    end
    return 32'h0;
  endfunction

  // One clock: model follows the edge, ports compared at the falling edge
  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    check("R13 irq", {31'h0, irq}, {31'h0, |(m_stat[5:0] & m_ien)});
    check("R3 init pulse", {31'h0, eng_init}, {31'h0, m_ctrl[1]});
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, string tag);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    check(tag, bus_rdata, model_read(a));
    tick();
  endtask

  task automatic dump(string tag);
    for (int a = 0; a <= 'h40; a += 4) rd(8'(a), tag);
  endtask

  task automatic dbyte(logic [7:0] b); wr(8'h10, {24'h0, b}); endtask

  task automatic par(logic [7:0] b);
    eng_par_vld = 1'b1; eng_par_byte = b; tick(); eng_par_vld = 1'b0;
  endtask

  task automatic eix(logic [12:0] p);
    eng_err_vld = 1'b1; eng_err_pos = p; tick(); eng_err_vld = 1'b0;
  endtask

  task automatic res(logic [6:0] t, logic u);
    eng_res_vld = 1'b1; eng_err_total = t; eng_uncor = u; tick(); eng_res_vld = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    eng_par_vld = 1'b0; eng_par_byte = '0; eng_err_vld = 1'b0; eng_err_pos = '0;
    eng_res_vld = 1'b0; eng_err_total = '0; eng_uncor = 1'b0;
    m_ctrl = '0; m_enc = 0; m_dec = 0; m_ien = '0;
    model_clear_op();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    dump("R1 reset");

    // R2 control aliases
    wr(8'h00, 32'hF);        rd(8'h00, "R2 direct write ignored");
    wr(8'h04, 32'h5);        rd(8'h00, "R2 set alias");
    wr(8'h08, 32'h4);        rd(8'h00, "R2 clear alias");
    wr(8'h04, 32'h8);        rd(8'h00, "R2 encode select");

    // R4 count register
    wr(8'h0C, 32'hFFFF_FFFF); rd(8'h0C, "R4 field mask");
    wr(8'h0C, 32'h000C_0005); rd(8'h0C, "R4 limits");

    // R3 init
    wr(8'h04, 32'h2);
    rd(8'h00, "R3 init visible");
    rd(8'h00, "R3 init self-clears");

    // R13 mask aliases
    wr(8'h3C, 32'h0F); wr(8'h40, 32'h03); rd(8'h38, "R13 mask");

    // R5 encode run with R10 parity packing
    dbyte(8'h11); dbyte(8'h22); dbyte(8'h33); dbyte(8'h44);
    rd(8'h24, "R5 not yet done");
    for (int k = 0; k < 7; k++) par(8'hA0 + 8'(k));
    dbyte(8'h55);
    rd(8'h24, "R5 encode done");
    dump("R10 parity words");

    // R8 / R12 after completion
    dbyte(8'h66); par(8'hEE); eix(13'd7); res(7'd5, 1'b1);
    dump("R12 frozen after done");

    // R9 write-one-to-clear
    wr(8'h24, 32'h0);  rd(8'h24, "R9 zero write keeps");
    wr(8'h24, 32'h4);  rd(8'h24, "R9 clear done");

    // R6 / R11 decode run
    wr(8'h08, 32'h8); wr(8'h04, 32'h2); tick();
    dump("R3 cleared by init");
    for (int k = 0; k < 11; k++) dbyte(8'(k * 7 + 1));
    eix(13'd5); eix(13'd100); eix(13'd4000); res(7'd3, 1'b0);
    dbyte(8'h9C);
    rd(8'h24, "R6 decode status");
    dump("R11 error words");
    wr(8'h24, 32'h3000_0001); rd(8'h24, "R9 partial clear");

    // R8 disabled writes, then R7 all-0xFF decode
    wr(8'h04, 32'h2); tick();
    wr(8'h08, 32'h1);
    for (int k = 0; k < 12; k++) dbyte(8'hFF);
    rd(8'h24, "R8 disabled ignored");
    wr(8'h04, 32'h1);
    for (int k = 0; k < 11; k++) dbyte(8'hFF);
    rd(8'h24, "R8 count restarts");
    dbyte(8'hFF);
    rd(8'h24, "R7 all ones");

    // R7 all-zero encode, R5 short count
    wr(8'h04, 32'hA); tick();
    for (int k = 0; k < 5; k++) dbyte(8'h00);
    rd(8'h24, "R7 all zero");

    // R6 uncorrectable
    wr(8'h08, 32'h8); wr(8'h04, 32'h2); tick();
    res(7'd9, 1'b1);
    for (int k = 0; k < 12; k++) dbyte(8'(k + 3));
    rd(8'h24, "R6 uncorrectable");

    // R10 / R11 capacity limits
    wr(8'h04, 32'h2); tick();
    for (int k = 0; k < 17; k++) par(8'(k + 1));
    for (int k = 0; k < 9; k++) eix(13'(k * 1000 + 1));
    dump("R10 R11 capacity");
    for (int k = 0; k < 12; k++) dbyte(8'(k));
    rd(8'h24, "R6 count of positions");

    // R5 zero limit never completes
    wr(8'h0C, 32'h0000_0000); wr(8'h04, 32'hA); tick();
    for (int k = 0; k < 4; k++) dbyte(8'h12);
    rd(8'h24, "R5 zero limit");

    // R13 unmasked then cleared
    wr(8'h0C, 32'h0000_0001); wr(8'h04, 32'h2); tick();
    dbyte(8'h01); wr(8'h3C, 32'h3F);
    rd(8'h38, "R13 all enabled");
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, "R9 full clear");

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule